// File: doc/BRIEF.md
# Two-Input Ones Tally, Multiple-of-Four Flag

This block keeps a running tally of how many of its two single-bit inputs are high across successive clock cycles. In each cycle the tally goes up by the number of inputs that are high: none, one or two. Only the tally modulo 2^CNT_W is kept. With the default CNT_W = 2 that is two flip-flops holding the count modulo 4.

A single flag output is decoded from the stored tally alone, so it is a Moore output. It is high exactly when the total number of ones seen since the last reset is a multiple of 2^CNT_W. With the default width that means a multiple of four.

A synchronous reset clears the tally, so the flag reads high straight after reset. Typical uses are parity-like grouping of events that arrive on two lanes, or pacing an action to every fourth event.

Top module: `ones_tally_mod`

## Requirements
- R1: In a cycle with reset low where both bit_a and bit_b are 1, the stored tally advances by 2 at the next rising clock edge.
- R2: In a cycle with reset low where exactly one of bit_a and bit_b is 1, the stored tally advances by 1 at the next rising clock edge.
- R3: In a cycle with reset low where both inputs are 0, the stored tally is unchanged, and so is the flag.
- R4: Output aligned is 1 exactly when the total count of ones since the last reset is a multiple of 2^CNT_W. For the default CNT_W = 2 these totals are 0, 4, 8 and so on.
- R5: When rst is 1 at a rising clock edge, the tally becomes 0 whatever the inputs are, so aligned is 1 after that edge.
- R6: The tally wraps modulo 2^CNT_W. With CNT_W = 2, a tally of 3 plus 2 gives 1 and a tally of 3 plus 1 gives 0.
- R7: Output aligned depends only on the stored tally. A change on bit_a or bit_b between clock edges does not change aligned before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the tally |
| bit_a | input | 1 | First event input; 1 adds one to the tally |
| bit_b | input | 1 | Second event input; 1 adds one to the tally |
| aligned | output | 1 | High when the tally is 0 modulo 2^CNT_W |

## Verification
The bench builds two copies of the block side by side and drives both with the same input stream.
- The first copy uses the default CNT_W = 2. It brings the modulo-4 wrap cases (3+1 and 3+2) within reach after only a few steps.
- The second copy uses CNT_W = 3. It shows that the flag decodes the full modulus and not a fixed count of four: at a total of four ones it must stay low while the first copy goes high.

A mid-cycle input change is made while the flag is low, to show that the flag waits for the clock edge.

// File: rtl/ones_tally_pkg.sv
package ones_tally_pkg;

    // How far the tally moves in one cycle.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } step_e;

endpackage

// File: rtl/step_classify.sv
module step_classify
    import ones_tally_pkg::*;
(
    input  logic  bit_a,
    input  logic  bit_b,
    output step_e step
);

    always_comb begin
        unique case ({bit_a, bit_b})
            2'b11:        step = STEP_TWO;
            2'b10, 2'b01: step = STEP_ONE;
            default:      step = STEP_NONE;
        endcase
    end

endmodule

// File: rtl/tally_counter.sv
module tally_counter
    import ones_tally_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] INC_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] INC_TWO = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_d;
    state_t st_q;

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.count = '0;
        end else begin
            unique case (step)
                STEP_ONE: st_d.count = st_q.count + INC_ONE;
                STEP_TWO: st_d.count = st_q.count + INC_TWO;
                default:  st_d.count = st_q.count;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_q = st_q.count;

    assert_step2_R1: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_TWO) |=> (count_q == $past(count_q) + INC_TWO));

    assert_step1_R2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ONE) |=> (count_q == $past(count_q) + INC_ONE));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_NONE) |=> $stable(count_q));

    assert_clear_R5: assert property (@(posedge clk)
        rst |=> (count_q == '0));

endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] count,
    output logic             is_zero
);

    always_comb begin
        is_zero = (count == '0);
    end

endmodule

// File: rtl/ones_tally_mod.sv
module ones_tally_mod
    import ones_tally_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_a,
    input  logic bit_b,
    output logic aligned
);

    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    step_e            step;
    logic [CNT_W-1:0] count_q;

    step_classify u_step (
        .bit_a (bit_a),
        .bit_b (bit_b),
        .step  (step)
    );

    tally_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .count_q (count_q)
    );

    zero_detect #(.CNT_W(CNT_W)) u_zero (
        .count   (count_q),
        .is_zero (aligned)
    );

    // Wrap from the top value: +2 lands on 1, +1 lands on 0.
    assert_wrap2_R6: assert property (@(posedge clk) disable iff (rst)
        (count_q == TOP_VAL && bit_a && bit_b) |=> (count_q == CNT_W'(1)));

    assert_wrap1_R6: assert property (@(posedge clk) disable iff (rst)
        (count_q == TOP_VAL && (bit_a ^ bit_b)) |=> aligned);

    // The flag can only rise after a cycle in which some input was high.
    assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!bit_a && !bit_b) |=> !$rose(aligned));

endmodule

// File: tb/test_ones_tally_mod.sv
module test_ones_tally_mod;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_a = 1'b0;
    logic bit_b = 1'b0;
    logic aligned;
    logic aligned_w3;

    int n_checks = 0;
    int n_fails  = 0;
    int tally    = 0;

    always #4 clk = ~clk;

    ones_tally_mod i_ones_tally_mod (
        .clk     (clk),
        .rst     (rst),
        .bit_a   (bit_a),
        .bit_b   (bit_b),
        .aligned (aligned)
    );

    ones_tally_mod #(.CNT_W(3)) i_ones_tally_mod_w3 (
        .clk     (clk),
        .rst     (rst),
        .bit_a   (bit_a),
        .bit_b   (bit_b),
        .aligned (aligned_w3)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b (tally %0d)", req, act, exp, tally);
        end
    endtask

    // Both copies against the software tally.
    task automatic check_both(input string req);
        check_bit(req, aligned,    logic'((tally % 4) == 0));
        check_bit(req, aligned_w3, logic'((tally % 8) == 0));
    endtask

    // Called at a falling edge: drive inputs, pass one rising edge,
    // return at the next falling edge and compare.
    task automatic apply(input logic a, input logic b, input string req);
        bit_a = a;
        bit_b = b;
        @(posedge clk);
        @(negedge clk);
        tally = tally + int'(a) + int'(b);
        check_both(req);
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        bit_a = 1'b1;
        bit_b = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bit_a = 1'b0;
        bit_b = 1'b0;
        tally = 0;
        check_both(req);
    endtask

    task automatic t_reset;
        do_reset("R5 initial reset");
        apply(1'b1, 1'b0, "R2 leave zero");
        apply(1'b1, 1'b1, "R1 to three");
        do_reset("R5 reset from nonzero");
    endtask

    task automatic t_hold;
        apply(1'b0, 1'b1, "R2 to one");
        for (int i = 0; i < 4; i++) apply(1'b0, 1'b0, "R3 idle holds");
        do_reset("R5 clear");
    endtask

    task automatic t_single;
        apply(1'b1, 1'b0, "R2 a only");
        apply(1'b0, 1'b1, "R2 b only");
        apply(1'b1, 1'b0, "R2 a only");
        apply(1'b0, 1'b1, "R2 four reached");
        for (int i = 0; i < 4; i++) apply(1'b1, 1'b0, "R2 to eight");
        do_reset("R5 clear");
    endtask

    task automatic t_double;
        apply(1'b1, 1'b1, "R1 two");
        apply(1'b1, 1'b1, "R1 four");
        apply(1'b1, 1'b1, "R1 six");
        apply(1'b1, 1'b1, "R1 eight");
        do_reset("R5 clear");
    endtask

    task automatic t_wrap;
        apply(1'b1, 1'b1, "R1 two");
        apply(1'b1, 1'b0, "R2 three");
        apply(1'b1, 1'b1, "R6 three plus two");
        apply(1'b1, 1'b1, "R6 to three again");
        apply(1'b0, 1'b1, "R6 three plus one");
        do_reset("R5 clear");
    endtask

    task automatic t_moore;
        apply(1'b1, 1'b1, "R1 two");
        apply(1'b0, 1'b1, "R2 three");
        bit_a = 1'b1;
        bit_b = 1'b0;
        #1;
        check_bit("R7 no change before edge", aligned, 1'b0);
        bit_a = 1'b1;
        bit_b = 1'b1;
        #1;
        check_bit("R7 no change before edge", aligned, 1'b0);
        bit_b = 1'b0;
        #1;
        apply(1'b1, 1'b0, "R7 edge applies step");
        do_reset("R5 clear");
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            automatic logic ra = logic'($urandom & 1);
            automatic logic rb = logic'(($urandom >> 3) & 1);
            apply(ra, rb, "R4 random stream");
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_single();
        t_double();
        t_wrap();
        t_moore();
        t_random();
        finish_run();
    end

endmodule